// File: doc/BRIEF.md
# Pseudo-Carry Prefix Adder

This block adds two unsigned operands and a carry-in without a clock. It never forms a carry chain. Each bit produces a generate term (AND of the operand bits) and a propagate term (inclusive OR of the operand bits). A logarithmic prefix tree then merges these terms into group pseudo-carries and group transmit terms. A real carry is formed only at the point where a sum bit needs it, as the AND of the propagate of the bit below and the pseudo-carry of the bit below. Generate always implies propagate, so each pseudo-carry is a factor of the true carry with one propagate term removed. This takes a literal off the critical combine path.

The tree treats the carry-in as an extra bit below bit 0. That bit's generate equals the carry-in and its propagate is forced to one. The first tree level merges neighbouring bits in pairs and needs no propagate term. Each later level merges three adjacent groups in one node, so the group span grows 2, 6, 18, 54 and so on until it covers the whole word. The width is a parameter, and the number of three-way levels is derived from it.

Top module: `pseudo_carry_adder`

## Requirements
- R1: For every input, {carry_out, sum_out} equals op_a + op_b + carry_in, computed at WIDTH+1 bits.
- R2: With op_b zero and carry_in zero, sum_out equals op_a and carry_out is 0.
- R3: carry_out is 1 exactly when the top bit generates (both operand bits 1), or when the top bit propagates (either operand bit 1) and a carry enters the top bit. The carry into the top bit is sum_out[WIDTH-1] XOR op_a[WIDTH-1] XOR op_b[WIDTH-1].
- R4: sum_out[0] equals op_a[0] XOR op_b[0] XOR carry_in. The carry-in acts as a generate below bit 0.
- R5: When op_b is the bitwise complement of op_a, every bit propagates and none generates. With carry_in 0 the result is sum_out all ones and carry_out 0. With carry_in 1 the result is sum_out all zeros and carry_out 1.
- R6: When carry_in is 0 and op_a AND op_b is zero, no carry forms: sum_out equals op_a OR op_b and carry_out is 0.
- R7: A carry-in of 1 travels through a run of ones in op_a (op_b zero) and stops at the first zero. For op_a = 2^k - 1 with k from 0 to WIDTH-1, the result is sum_out = 2^k and carry_out 0. For k = WIDTH, the result is sum_out zero and carry_out 1.
- R8: The block is purely combinational. The outputs follow a change of the inputs within the same time step, with no clock edge between them.
- R9: The all-ones operands with carry-in 1 produce sum_out all ones and carry_out 1. This is the largest result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bound checker tests every settled input combination the bench applies. It checks the exact sum, the low-bit rule, the carry-out rule at the top bit, the no-carry rule for disjoint operands, and the all-propagate case. The bench's own checks cover properties that need a chosen stimulus or a timing view. These are the run of ones that a carry-in must ripple through and stop at each position (R7), the identity case, the saturating corner of all ones, and the lack of any clocked stage between an input change and the output (R8).

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int PCA_WIDTH = 32;

    // one prefix node: pseudo-carry of the group and its transmit term
    typedef struct packed {
        logic h;
        logic i;
    } lc_node_t;

    // number of three-way levels after the pair level so that the
    // group span (2 * 3^n) covers WIDTH bits plus the carry-in slot
    function automatic int tri_levels(input int w);
        int span;
        int n;
        span = 2;
        n = 0;
        while (span < w + 1) begin
            span = span * 3;
            n = n + 1;
        end
        return n;
    endfunction

    // span of the groups entering three-way level lvl (lvl >= 1)
    function automatic int tri_span(input int lvl);
        int s;
        s = 2;
        for (int q = 1; q < lvl; q++) begin
            s = s * 3;
        end
        return s;
    endfunction

    function automatic lc_node_t merge3(input lc_node_t hi, input lc_node_t mid,
                                        input lc_node_t lo);
        lc_node_t r;
        r.h = hi.h | (hi.i & mid.h) | (hi.i & mid.i & lo.h);
        r.i = hi.i & mid.i & lo.i;
        return r;
    endfunction

    function automatic lc_node_t merge2(input lc_node_t hi, input lc_node_t lo);
        lc_node_t r;
        r.h = hi.h | (hi.i & lo.h);
        r.i = hi.i & lo.i;
        return r;
    endfunction

endpackage

// File: rtl/pca_bit_cells.sv
module pca_bit_cells #(
    parameter int W = pca_pkg::PCA_WIDTH
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   gen,   // slot 0 is the carry-in, slot k+1 is bit k
    output logic [W:0]   prop,
    output logic [W-1:0] half
);
    // the carry-in slot generates when cin is set and always propagates
    assign gen[0]  = cin;
    assign prop[0] = 1'b1;

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign gen[k+1]  = a[k] & b[k];
        assign prop[k+1] = a[k] | b[k];
        assign half[k]   = a[k] ^ b[k];
    end
endmodule

// File: rtl/pca_prefix_tree.sv
module pca_prefix_tree
    import pca_pkg::*;
#(
    parameter int W = pca_pkg::PCA_WIDTH
) (
    input  logic [W:0] gen,
    input  logic [W:0] prop,
    output logic [W:0] hsum    // pseudo-carry of slots k..0
);
    localparam int NT = tri_levels(W);
    localparam int NS = NT + 2;   // base, pair, then NT three-way levels

    lc_node_t [NS-1:0][W:0] nd;

    // base: a single slot, transmit term shifted down by one position
    for (genvar k = 0; k <= W; k++) begin : g_base
        if (k == 0) begin : g_lsb
            assign nd[0][k] = '{h: gen[k], i: 1'b0};
        end else begin : g_up
            assign nd[0][k] = '{h: gen[k], i: prop[k-1]};
        end
    end

    // pair level: the propagate factor vanishes because gen implies prop
    for (genvar k = 0; k <= W; k++) begin : g_pair
        if (k == 0) begin : g_lsb
            assign nd[1][k] = nd[0][k];
        end else begin : g_up
            assign nd[1][k] = '{h: gen[k] | gen[k-1],
                                i: nd[0][k].i & nd[0][k-1].i};
        end
    end

    // three-way levels with span 2, 6, 18, ...
    for (genvar l = 2; l < NS; l++) begin : g_lvl
        localparam int S = tri_span(l - 1);
        for (genvar k = 0; k <= W; k++) begin : g_node
            if (k >= 2 * S) begin : g_three
                assign nd[l][k] = merge3(nd[l-1][k], nd[l-1][k-S], nd[l-1][k-2*S]);
            end else if (k >= S) begin : g_two
                assign nd[l][k] = merge2(nd[l-1][k], nd[l-1][k-S]);
            end else begin : g_done
                assign nd[l][k] = nd[l-1][k];
            end
        end
    end

    for (genvar k = 0; k <= W; k++) begin : g_out
        assign hsum[k] = nd[NS-1][k].h;
    end
endmodule

// File: rtl/pca_sum_stage.sv
module pca_sum_stage #(
    parameter int W = pca_pkg::PCA_WIDTH
) (
    input  logic [W-1:0] half,
    input  logic [W:0]   prop,
    input  logic [W:0]   hsum,
    output logic [W-1:0] sum,
    output logic         cout
);
    // carry into bit n = carry out of slot n = prop[n] & hsum[n]
    for (genvar n = 0; n < W; n++) begin : g_sum
        assign sum[n] = half[n] ^ (prop[n] & hsum[n]);
    end
    assign cout = prop[W] & hsum[W];
endmodule

// File: rtl/pseudo_carry_adder.sv
module pseudo_carry_adder #(
    parameter int WIDTH = pca_pkg::PCA_WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    logic [WIDTH:0]   gen_w;
    logic [WIDTH:0]   prop_w;
    logic [WIDTH-1:0] half_w;
    logic [WIDTH:0]   hsum_w;

    pca_bit_cells #(.W(WIDTH)) u_cells (
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .gen  (gen_w),
        .prop (prop_w),
        .half (half_w)
    );

    pca_prefix_tree #(.W(WIDTH)) u_tree (
        .gen  (gen_w),
        .prop (prop_w),
        .hsum (hsum_w)
    );

    pca_sum_stage #(.W(WIDTH)) u_sum (
        .half (half_w),
        .prop (prop_w),
        .hsum (hsum_w),
        .sum  (sum_out),
        .cout (carry_out)
    );
endmodule

// File: rtl/pca_adder_chk.sv
module pca_adder_chk #(
    parameter int W = pca_pkg::PCA_WIDTH
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout
);
    logic [W:0] ref_total;
    logic       top_cin;

    always_comb begin
        ref_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        top_cin   = sum[W-1] ^ a[W-1] ^ b[W-1];
        if (!$isunknown({a, b, cin})) begin
            assert_exact_sum_R1: assert ({cout, sum} == ref_total)
                else $error("R1 sum mismatch");
            assert_low_bit_R4: assert (sum[0] == (a[0] ^ b[0] ^ cin))
                else $error("R4 bit 0 mismatch");
            assert_top_carry_R3: assert (cout == ((a[W-1] & b[W-1]) |
                                                  ((a[W-1] | b[W-1]) & top_cin)))
                else $error("R3 carry-out rule broken");
            if (!cin && ((a & b) == '0)) begin
                assert_disjoint_R6: assert ((sum == (a | b)) && !cout)
                    else $error("R6 disjoint operands carried");
            end
            if (b == ~a) begin
                assert_all_prop_R5: assert ((sum == {W{~cin}}) && (cout == cin))
                    else $error("R5 all-propagate case wrong");
            end
        end
    end
endmodule

bind pseudo_carry_adder pca_adder_chk #(.W(WIDTH)) u_pca_chk (
    .a    (op_a),
    .b    (op_b),
    .cin  (carry_in),
    .sum  (sum_out),
    .cout (carry_out)
);

// File: tb/pseudo_carry_adder_bench.sv
module pseudo_carry_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int N_RANDOM = 3000;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic [W:0]   expv;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 33'h0_0000_0000},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000},
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 33'h1_0000_0000},
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000},
        '{32'h1234_5678, 32'h8765_4321, 1'b0, 33'h0_9999_9999},
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 33'h0_8000_0000},
        '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 33'h1_0000_0000},
        '{32'h0000_0000, 32'h0000_0000, 1'b1, 33'h0_0000_0001}
    };

    logic         clk;
    logic         rst;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         carry_in;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int  n_checks;
    int  n_fail;
    bit  finished;

    pseudo_carry_adder #(.WIDTH(W)) u_pseudo_carry_adder (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, expv);
        end
    endtask

    // drive after a rising edge, sample a quarter period later
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        @(posedge clk);
        op_a = a;
        op_b = b;
        carry_in = c;
        #(CLK_PERIOD / 4);
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    initial begin
        n_checks = 0;
        n_fail   = 0;
        finished = 1'b0;
        rst      = 1'b1;
        op_a     = '0;
        op_b     = '0;
        carry_in = 1'b0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 4);
        check("R1 reset-time zero inputs", {carry_out, sum_out}, '0);
        rst = 1'b0;

        // table walk: R1, R5 (alternating complements), R9 (all ones)
        for (int v = 0; v < 10; v++) begin
            apply(VECS[v].a, VECS[v].b, VECS[v].cin);
            check((v == 1) ? "R9 all ones" : "R1 vector table",
                  {carry_out, sum_out}, VECS[v].expv);
        end

        // R2 identity
        apply(32'hDEAD_BEEF, '0, 1'b0);
        check("R2 add zero", {carry_out, sum_out}, {1'b0, 32'hDEAD_BEEF});

        // R4 carry-in enters at bit 0 only
        apply(32'h0000_0002, 32'h0000_0000, 1'b1);
        check("R4 low bit with carry-in", {carry_out, sum_out}, 33'h0_0000_0003);

        // R5 all propagate, both carry-in values
        apply(32'h0F0F_3C3C, ~32'h0F0F_3C3C, 1'b0);
        check("R5 complement cin0", {carry_out, sum_out}, 33'h0_FFFF_FFFF);
        apply(32'h0F0F_3C3C, ~32'h0F0F_3C3C, 1'b1);
        check("R5 complement cin1", {carry_out, sum_out}, 33'h1_0000_0000);

        // R6 disjoint operands
        apply(32'hF0F0_0F0F, 32'h0F0F_F0F0 & 32'h0000_F0F0, 1'b0);
        check("R6 disjoint", {carry_out, sum_out}, {1'b0, 32'hF0F0_FFFF});

        // R7 carry from cin ripples through a run of k ones and stops
        for (int k = 0; k <= W; k++) begin
            logic [W-1:0] run;
            logic [W:0]   expv;
            run  = (k == W) ? '1 : ((32'h1 << k) - 32'h1);
            expv = 33'h1 << k;
            apply(run, '0, 1'b1);
            check("R7 ripple run", {carry_out, sum_out}, expv);
        end

        // R8 output follows an input change with no clock edge between
        @(negedge clk);
        op_a = 32'h0000_FFFF;
        op_b = 32'h0000_0001;
        carry_in = 1'b0;
        #1;
        check("R8 same-step update", {carry_out, sum_out}, 33'h0_0001_0000);
        op_b = 32'hFFFF_0001;
        #1;
        check("R8 second update", {carry_out, sum_out}, 33'h1_0000_0000);

        // R1 random sweep
        for (int r = 0; r < N_RANDOM; r++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            logic         rc;
            ra = $urandom();
            rb = $urandom();
            rc = 1'($urandom());
            apply(ra, rb, rc);
            check("R1 random", {carry_out, sum_out}, model(ra, rb, rc));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule